// File: doc/BRIEF.md
# Edge-Programmable PWM Channel

This block is a single pulse-width-modulated output channel. Each period is a count from zero up to a programmable base length minus one. The pulse is not set by one duty value. It is bounded by two compare points inside the period: the output turns on at the rise point and turns off at the fall point. An invert setting flips the pin polarity. The counter advances only on a prescaled tick input, so the period unit is set outside the block.

Software-facing settings arrive as a register image that the host bus logic has already decoded. A timing word and an optional extension word carry the rise, fall and base values, and separate strobes write the timing fields, the invert flag and a repeat count. A start strobe copies the written settings into the running stage and begins counting. A repeat count of zero runs the channel with no end. A nonzero count ends the run after that many periods. A stop strobe ends a run at once. Both endings raise a one-cycle done pulse. While the channel runs, a load strobe arms a transfer of newly written timing values, and the transfer takes place at the next period boundary.

Top module: `edge_pwm_channel`

## Requirements
- R1: A timing write takes the rise point from bits 7:0 of the timing word, the fall point from bits 15:8 and the base length from bits 23:16. With the wide option (the default), the extension word supplies the upper byte of each value in the same byte positions (rise 7:0, fall 15:8, base 23:16), which gives 16-bit values.
- R2: A period lasts base ticks, with the count running 0 to base-1. The pin is active exactly while rise <= count < fall. Rise and fall both zero give a constantly inactive pin.
- R3: A base length below 2 is handled as 2.
- R4: The invert flag is bit 28 of the timing word and is captured only on an invert write. A timing write leaves it unchanged. When idle, the pin rests at the inactive level: 0, or 1 when invert is set.
- R5: A repeat count of zero makes the channel run until stopped. Busy stays high and no done pulse appears.
- R6: A nonzero repeat count N ends the run after N full periods. Busy falls and done pulses for exactly one cycle on the same clock edge.
- R7: A stop strobe on a running channel drops busy on the next clock edge and pulses done. A stop strobe while idle raises no done.
- R8: Timing writes during a run have no effect until a load strobe. After a load, the new rise, fall and base take effect at the next period boundary, and the current period completes.
- R9: The count advances only in cycles where the tick input is high.
- R10: A start strobe while idle copies the written settings and begins at count 0. The pin is registered and shows count k one clock after the counter holds k. A start strobe while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Prescaled count enable |
| timing_word | input | 32 | Rise [7:0], fall [15:8], base [23:16], invert [28] |
| ext_word | input | 24 | Upper bytes of rise [7:0], fall [15:8], base [23:16] |
| wr_timing | input | 1 | Write rise, fall and base into the shadow stage |
| wr_invert | input | 1 | Write the invert flag from timing_word[28] |
| repeat_in | input | 16 | Repeat count, 0 means free-run |
| wr_repeat | input | 1 | Write the repeat count |
| start | input | 1 | Begin a run from the shadow settings |
| stop | input | 1 | End a run immediately |
| load | input | 1 | Arm a timing transfer at the next period boundary |
| pwm_out | output | 1 | Registered PWM pin |
| busy | output | 1 | Channel is running |
| done | output | 1 | One-cycle pulse when a run ends |

## Verification
The bench looks at the period boundary from several sides. A wrong terminal compare shows up as a period one tick too long or too short, and the fully predicted pin sequence catches this. A load that lands mid-period or on the wrong boundary shifts the new pattern by a whole period, and an early repeat end or a missing done pulse shows up in the busy and done columns. The wide test places the only active count at 256, so a design that drops the extension byte either never pulses or pulses at the wrong count. Other tests hold the tick low, which exposes a counter that runs on the raw clock, and write timing with bit 28 clear while invert is set, which exposes a timing write that clobbers the polarity. A zero base must give a two-tick period rather than hanging or wrapping.

// File: rtl/epwm_pkg.sv
package epwm_pkg;

  localparam int unsigned EPWM_VAL_W = 16;

  typedef struct packed {
    logic [EPWM_VAL_W-1:0] rise;
    logic [EPWM_VAL_W-1:0] fall;
    logic [EPWM_VAL_W-1:0] base;
  } epwm_timing_t;

  typedef enum logic {
    CH_IDLE = 1'b0,
    CH_RUN  = 1'b1
  } ch_state_t;

endpackage

// File: rtl/epwm_shadow.sv
module epwm_shadow
  import epwm_pkg::*;
#(
  parameter bit          WIDE  = 1'b1,
  parameter int unsigned REP_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [31:0]        timing_word,
  input  logic [23:0]        ext_word,
  input  logic               wr_timing,
  input  logic               wr_invert,
  input  logic [REP_W-1:0]   repeat_in,
  input  logic               wr_repeat,
  output epwm_timing_t       sh_timing,
  output logic               sh_invert,
  output logic [REP_W-1:0]   sh_repeat
);

  localparam int unsigned LO_W = 8;
  localparam int unsigned HI_W = EPWM_VAL_W - LO_W;
  localparam int unsigned INV_BIT = 28;
  localparam logic [EPWM_VAL_W-1:0] BASE_FLOOR = EPWM_VAL_W'(2);

  logic [HI_W-1:0] hi_rise, hi_fall, hi_base;
  logic [EPWM_VAL_W-1:0] in_rise, in_fall, in_base, base_fixed;
  logic unused_word_bits;

  generate
    if (WIDE) begin : g_wide
      assign hi_rise = ext_word[7:0];
      assign hi_fall = ext_word[15:8];
      assign hi_base = ext_word[23:16];
      assign unused_word_bits = ^{timing_word[31:29], timing_word[27:24]};
    end else begin : g_narrow
      assign hi_rise = '0;
      assign hi_fall = '0;
      assign hi_base = '0;
      assign unused_word_bits = ^{timing_word[31:29], timing_word[27:24], ext_word};
    end
  endgenerate

  assign in_rise = {hi_rise, timing_word[7:0]};
  assign in_fall = {hi_fall, timing_word[15:8]};
  assign in_base = {hi_base, timing_word[23:16]};
  assign base_fixed = (in_base < BASE_FLOOR) ? BASE_FLOOR : in_base;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_timing <= '{rise: '0, fall: '0, base: BASE_FLOOR};
      sh_invert <= 1'b0;
      sh_repeat <= '0;
    end else begin
      if (wr_timing) begin
        sh_timing.rise <= in_rise;
        sh_timing.fall <= in_fall;
        sh_timing.base <= base_fixed;
      end
      if (wr_invert) sh_invert <= timing_word[INV_BIT];
      if (wr_repeat) sh_repeat <= repeat_in;
    end
  end

  // R3: stored base never below the floor
  assert_base_floor_R3: assert property (@(posedge clk) disable iff (rst)
    sh_timing.base >= BASE_FLOOR);

  // R4: invert only moves on its own strobe
  assert_invert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !wr_invert |=> $stable(sh_invert));

endmodule

// File: rtl/epwm_sequencer.sv
module epwm_sequencer
  import epwm_pkg::*;
#(
  parameter int unsigned REP_W = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   tick,
  input  logic                   start,
  input  logic                   stop,
  input  logic                   load,
  input  epwm_timing_t           sh_timing,
  input  logic [REP_W-1:0]       sh_repeat,
  output epwm_timing_t           act_timing,
  output logic [EPWM_VAL_W-1:0]  cnt_q,
  output logic                   run_q,
  output logic                   done_q
);

  localparam logic [EPWM_VAL_W-1:0] ONE = EPWM_VAL_W'(1);
  localparam logic [REP_W-1:0]      REP_ONE = REP_W'(1);

  ch_state_t        state_q;
  logic [REP_W-1:0] act_repeat;
  logic [REP_W-1:0] periods_q;
  logic             pend_q;
  logic             at_end;
  logic             last_period;

  assign at_end      = (cnt_q == (act_timing.base - ONE));
  assign last_period = (act_repeat != '0) && ((periods_q + REP_ONE) == act_repeat);
  assign run_q       = (state_q == CH_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= CH_IDLE;
      act_timing <= '{rise: '0, fall: '0, base: EPWM_VAL_W'(2)};
      act_repeat <= '0;
      periods_q  <= '0;
      cnt_q      <= '0;
      pend_q     <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        CH_IDLE: begin
          if (start) begin
            act_timing <= sh_timing;
            act_repeat <= sh_repeat;
            periods_q  <= '0;
            cnt_q      <= '0;
            pend_q     <= 1'b0;
            state_q    <= CH_RUN;
          end
        end
        CH_RUN: begin
          if (stop) begin
            state_q <= CH_IDLE;
            done_q  <= 1'b1;
            pend_q  <= 1'b0;
          end else begin
            if (load) pend_q <= 1'b1;
            if (tick) begin
              if (at_end) begin
                cnt_q <= '0;
                if (last_period) begin
                  state_q   <= CH_IDLE;
                  done_q    <= 1'b1;
                  periods_q <= '0;
                  pend_q    <= 1'b0;
                end else begin
                  if (act_repeat != '0) periods_q <= periods_q + REP_ONE;
                  if (pend_q || load) begin
                    act_timing <= sh_timing;
                    pend_q     <= 1'b0;
                  end
                end
              end else begin
                cnt_q <= cnt_q + ONE;
              end
            end
          end
        end
        default: state_q <= CH_IDLE;
      endcase
    end
  end

  // R9: no tick, no count movement
  assert_hold_no_tick_R9: assert property (@(posedge clk) disable iff (rst)
    (run_q && !tick) |=> $stable(cnt_q));

  // R2: count stays inside the period
  assert_cnt_in_period_R2: assert property (@(posedge clk) disable iff (rst)
    run_q |-> (cnt_q < act_timing.base));

  // R3: active base never below two
  assert_active_base_R3: assert property (@(posedge clk) disable iff (rst)
    act_timing.base >= EPWM_VAL_W'(2));

  // R6: done lasts one cycle
  assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  // R6 / R7: done marks the end of a run
  assert_done_ends_run_R7: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (!run_q && $past(run_q)));

  // R10: idle start begins at count zero
  assert_start_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (!run_q && start) |=> (run_q && cnt_q == '0));

endmodule

// File: rtl/epwm_output.sv
module epwm_output
  import epwm_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  run,
  input  logic [EPWM_VAL_W-1:0] cnt,
  input  epwm_timing_t          act_timing,
  input  logic                  invert,
  output logic                  pwm_q
);

  logic in_window;

  assign in_window = run && (cnt >= act_timing.rise) && (cnt < act_timing.fall);

  always_ff @(posedge clk) begin
    if (rst) pwm_q <= 1'b0;
    else     pwm_q <= invert ^ in_window;
  end

  // R4: an idle channel drives the inactive level
  assert_idle_level_R4: assert property (@(posedge clk) disable iff (rst)
    !$past(run) |-> (pwm_q == $past(invert)));

endmodule

// File: rtl/edge_pwm_channel.sv
module edge_pwm_channel
  import epwm_pkg::*;
#(
  parameter bit          WIDE  = 1'b1,
  parameter int unsigned REP_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [31:0]      timing_word,
  input  logic [23:0]      ext_word,
  input  logic             wr_timing,
  input  logic             wr_invert,
  input  logic [REP_W-1:0] repeat_in,
  input  logic             wr_repeat,
  input  logic             start,
  input  logic             stop,
  input  logic             load,
  output logic             pwm_out,
  output logic             busy,
  output logic             done
);

  epwm_timing_t          sh_timing;
  epwm_timing_t          act_timing;
  logic                  sh_invert;
  logic [REP_W-1:0]      sh_repeat;
  logic [EPWM_VAL_W-1:0] cnt;
  logic                  run;

  epwm_shadow #(.WIDE(WIDE), .REP_W(REP_W)) u_shadow (
    .clk         (clk),
    .rst         (rst),
    .timing_word (timing_word),
    .ext_word    (ext_word),
    .wr_timing   (wr_timing),
    .wr_invert   (wr_invert),
    .repeat_in   (repeat_in),
    .wr_repeat   (wr_repeat),
    .sh_timing   (sh_timing),
    .sh_invert   (sh_invert),
    .sh_repeat   (sh_repeat)
  );

  epwm_sequencer #(.REP_W(REP_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .start      (start),
    .stop       (stop),
    .load       (load),
    .sh_timing  (sh_timing),
    .sh_repeat  (sh_repeat),
    .act_timing (act_timing),
    .cnt_q      (cnt),
    .run_q      (run),
    .done_q     (done)
  );

  epwm_output u_out (
    .clk        (clk),
    .rst        (rst),
    .run        (run),
    .cnt        (cnt),
    .act_timing (act_timing),
    .invert     (sh_invert),
    .pwm_q      (pwm_out)
  );

  assign busy = run;

endmodule

// File: tb/edge_pwm_channel_tb_top.sv
module edge_pwm_channel_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b1;
  logic [31:0] timing_word = '0;
  logic [23:0] ext_word = '0;
  logic        wr_timing = 1'b0;
  logic        wr_invert = 1'b0;
  logic [15:0] repeat_in = '0;
  logic        wr_repeat = 1'b0;
  logic        start = 1'b0;
  logic        stop = 1'b0;
  logic        load = 1'b0;
  logic        pwm_out, busy, done;

  int n_chk = 0;
  int n_bad = 0;
  bit mon_arm = 1'b0;
  logic [2:0] exp_q[$];
  string      tag_q[$];
  logic [2:0] mon_e;
  string      mon_t;

  always #4 clk = ~clk;

  edge_pwm_channel dut_i (
    .clk(clk), .rst(rst), .tick(tick),
    .timing_word(timing_word), .ext_word(ext_word),
    .wr_timing(wr_timing), .wr_invert(wr_invert),
    .repeat_in(repeat_in), .wr_repeat(wr_repeat),
    .start(start), .stop(stop), .load(load),
    .pwm_out(pwm_out), .busy(busy), .done(done)
  );

  // monitor: pops one expected {pwm,busy,done} per clock
  always @(posedge clk) begin
    #2;
    if (mon_arm && exp_q.size() > 0) begin
      mon_e = exp_q.pop_front();
      mon_t = tag_q.pop_front();
      n_chk++;
      if ({pwm_out, busy, done} !== mon_e) begin
        n_bad++;
        $display("FAIL %s: {pwm,busy,done} got %b expected %b", mon_t,
                 {pwm_out, busy, done}, mon_e);
      end
    end
  end

  function automatic bit pat(int r, int f, int c);
    return (c >= r) && (c < f);
  endfunction

  task automatic push(bit p, bit b, bit d, string t);
    exp_q.push_back({p, b, d});
    tag_q.push_back(t);
  endtask

  task automatic push_finite(int r, int f, int b, int reps, bit inv, string t);
    int nb;
    nb = reps * b;
    for (int j = 1; j <= nb; j++) push(inv ^ pat(r, f, (j - 1) % b), j < nb, j == nb, t);
    for (int j = 0; j < 2; j++) push(inv, 1'b0, 1'b0, t);
  endtask

  task automatic direct(string t, logic [2:0] got, logic [2:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", t, got, exp);
    end
  endtask

  task automatic set_cfg(logic [15:0] r, logic [15:0] f, logic [15:0] b,
                         bit inv, bit w_inv, logic [15:0] rep);
    @(negedge clk);
    timing_word = {3'b000, inv, 4'h0, b[7:0], f[7:0], r[7:0]};
    ext_word    = {b[15:8], f[15:8], r[15:8]};
    wr_timing   = 1'b1;
    wr_invert   = w_inv;
    repeat_in   = rep;
    wr_repeat   = 1'b1;
    @(negedge clk);
    wr_timing = 1'b0;
    wr_invert = 1'b0;
    wr_repeat = 1'b0;
  endtask

  task automatic launch();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0; mon_arm = 1'b1;
  endtask

  task automatic drain();
    wait (exp_q.size() == 0);
    @(negedge clk);
    mon_arm = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    direct("R10 reset state", {pwm_out, busy, done}, 3'b000);

    // R2 R6: two finite periods, rise 1 fall 4 base 6
    set_cfg(16'd1, 16'd4, 16'd6, 1'b0, 1'b0, 16'd2);
    push_finite(1, 4, 6, 2, 1'b0, "R6 finite repeat");
    launch(); drain();

    // R5 R7 R10: free-run, ignored restart, then stop
    set_cfg(16'd2, 16'd5, 16'd5, 1'b0, 1'b0, 16'd0);
    for (int j = 1; j <= 13; j++) push(pat(2, 5, (j - 1) % 5), 1'b1, 1'b0, "R5 free-run");
    push(pat(2, 5, 13 % 5), 1'b0, 1'b1, "R7 stop on run");
    for (int j = 0; j < 2; j++) push(1'b0, 1'b0, 1'b0, "R7 idle after stop");
    launch();
    repeat (2) @(negedge clk);
    @(negedge clk); start = 1'b1;   // R10 start while busy
    @(negedge clk); start = 1'b0;
    repeat (8) @(negedge clk);
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    drain();

    // R3: base 0 handled as 2
    set_cfg(16'd0, 16'd1, 16'd0, 1'b0, 1'b0, 16'd2);
    push_finite(0, 1, 2, 2, 1'b0, "R3 base floor");
    launch(); drain();

    // R2: rise = fall = 0 never active
    set_cfg(16'd0, 16'd0, 16'd4, 1'b0, 1'b0, 16'd1);
    push_finite(0, 0, 4, 1, 1'b0, "R2 zero window");
    launch(); drain();

    // R1: wide values, only count 256 active in a 258-tick period
    set_cfg(16'h0100, 16'h0101, 16'h0102, 1'b0, 1'b0, 16'd1);
    push_finite(256, 257, 258, 1, 1'b0, "R1 wide fields");
    launch(); drain();

    // R4: invert set, then a timing write with bit 28 clear keeps it
    set_cfg(16'd0, 16'd2, 16'd3, 1'b1, 1'b1, 16'd1);
    set_cfg(16'd0, 16'd2, 16'd3, 1'b0, 1'b0, 16'd1);
    repeat (2) @(negedge clk);
    direct("R4 idle inverted level", {pwm_out, busy, done}, 3'b100);
    push_finite(0, 2, 3, 1, 1'b1, "R4 inverted run");
    launch(); drain();
    set_cfg(16'd0, 16'd2, 16'd3, 1'b0, 1'b1, 16'd1);
    repeat (2) @(negedge clk);
    direct("R4 idle level cleared", {pwm_out, busy, done}, 3'b000);

    // R8: write without load ignored, load applies at boundary
    set_cfg(16'd0, 16'd1, 16'd4, 1'b0, 1'b0, 16'd0);
    for (int j = 1; j <= 8; j++) push(pat(0, 1, (j - 1) % 4), 1'b1, 1'b0, "R8 old period kept");
    for (int j = 9; j <= 18; j++) push(pat(1, 3, (j - 9) % 5), 1'b1, 1'b0, "R8 loaded period");
    push(pat(1, 3, 0), 1'b0, 1'b1, "R7 stop after load");
    for (int j = 0; j < 2; j++) push(1'b0, 1'b0, 1'b0, "R8 idle");
    launch();
    @(negedge clk);
    timing_word = {8'h00, 8'd5, 8'd3, 8'd1};
    ext_word    = '0;
    wr_timing   = 1'b1;
    @(negedge clk); wr_timing = 1'b0;
    repeat (2) @(negedge clk);
    @(negedge clk); load = 1'b1;
    @(negedge clk); load = 1'b0;
    repeat (11) @(negedge clk);
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    drain();

    // R9: tick held low freezes the count at 0
    set_cfg(16'd0, 16'd2, 16'd3, 1'b0, 1'b0, 16'd0);
    tick = 1'b0;
    for (int j = 1; j <= 6; j++) push(1'b1, 1'b1, 1'b0, "R9 no tick hold");
    push(1'b1, 1'b0, 1'b1, "R9 stop while held");
    for (int j = 0; j < 2; j++) push(1'b0, 1'b0, 1'b0, "R9 idle");
    launch();
    repeat (5) @(negedge clk);
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    drain();
    tick = 1'b1;

    // R7: stop while idle gives no done
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    direct("R7 stop while idle", {pwm_out, busy, done}, 3'b000);
    @(negedge clk);
    direct("R7 stop while idle later", {pwm_out, busy, done}, 3'b000);

    summary();
    $finish;
  end

endmodule